// File: doc/BRIEF.md
# Warp Issue Scheduler with Operand Scoreboard

This block chooses which resident warp of a streaming multiprocessor sends its next instruction. It holds a register busy map for every warp. A warp is eligible only when it is valid, has a pending instruction, and none of the registers that instruction names are waiting on an earlier result. On every cycle each scheduler slice picks one eligible warp in round-robin order. A warp that is blocked, whether by a missing load or by a result that has not been written back, is passed over and costs nothing. Each warp keeps its own register state, so changing warps carries no save or restore cost.

Warps are spread over 1, 2 or 4 scheduler slices by the low bits of the warp number. Each slice arbitrates only among its own warps and raises its own issue strobe. The strobe is combinational and acts as the fetch-advance handshake. The next instruction's register fields must be replaced before the following clock edge. A separate combinational path converts a thread's 3-D coordinates and block dimensions into its warp number, lane, scheduler slice and slot. Fetch, decode, execution and memory are modelled only through the register fields and the two completion ports.

Top module: `warp_issue_sched`

## Requirements
- R1: The linear thread number is tid_x + tid_y·dim_x + tid_z·dim_x·dim_y. `map_warp` equals that number divided by 32, and `map_lane` equals that number modulo 32.
- R2: Warp g belongs to scheduler slice g mod NUM_SCHED at slot g / NUM_SCHED. Field s of `issue_warp` (bits [s·WID_W +: WID_W]) reports the global warp number, and `map_sched` / `map_slot` give the slice and slot of `map_warp`.
- R3: Warp g is ready only when `warp_valid[g]`, `inst_vld[g]` and the busy bits of its source A, source B and destination registers are all clear. The register fields are taken from bits [g·REG_W +: REG_W] of the three index buses. A slice whose own warps include a ready one raises `issue_vld[s]` in the same cycle, and it never issues a warp that is not ready.
- R4: Issuing a warp sets `reg_busy[g·NUM_REGS + dst]` from the next clock edge onward.
- R5: A writeback event (`wb_vld`, `wb_warp`, `wb_reg`) clears that warp's busy bit at the next edge. A warp that was blocked only by that register becomes ready in the following cycle.
- R6: A load-return event (`ld_vld`, `ld_warp`, `ld_reg`) clears a busy bit in the same way. It may occur in the same cycle as a writeback to a different bit.
- R7: Within a slice, the chosen warp is the first ready slot after the slot last issued, wrapping around. After reset the search starts at slot 0.
- R8: When a slice has no ready warp, its strobe stays low and its round-robin position is kept unchanged.
- R9: A warp whose `warp_valid` bit is low is never issued, even when its registers are free.
- R10: Reset clears every busy bit and returns every slice to its initial round-robin position.
- R11: The slices are independent: a blocked or empty slice does not hold back issue from another slice in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid_x | input | COORD_W | Thread x coordinate |
| tid_y | input | COORD_W | Thread y coordinate |
| tid_z | input | COORD_W | Thread z coordinate |
| dim_x | input | COORD_W | Block x dimension |
| dim_y | input | COORD_W | Block y dimension |
| map_warp | output | 3·COORD_W−5 | Warp number of the thread |
| map_lane | output | 5 | Lane within the warp |
| map_sched | output | SCH_W | Scheduler slice owning that warp |
| map_slot | output | 3·COORD_W−5 | Slot of that warp inside its slice |
| warp_valid | input | NUM_WARPS | Warp is resident and active |
| inst_vld | input | NUM_WARPS | Warp has a decoded next instruction |
| src_a_idx | input | NUM_WARPS·REG_W | Source A register per warp |
| src_b_idx | input | NUM_WARPS·REG_W | Source B register per warp |
| dst_idx | input | NUM_WARPS·REG_W | Destination register per warp |
| wb_vld | input | 1 | Writeback event |
| wb_warp | input | WID_W | Writeback warp |
| wb_reg | input | REG_W | Writeback register |
| ld_vld | input | 1 | Load-return event |
| ld_warp | input | WID_W | Load-return warp |
| ld_reg | input | REG_W | Load-return register |
| issue_vld | output | NUM_SCHED | Issue strobe per slice |
| issue_warp | output | NUM_SCHED·WID_W | Issued global warp number per slice |
| reg_busy | output | NUM_WARPS·NUM_REGS | Busy marks, bit g·NUM_REGS+r |

## Verification
The first pattern makes every warp ready on every cycle, so only the round-robin order decides the issue sequence. This separates a correct rotation from one that always favours low slots, and it separates correct slice ownership from a mix-up of slices. Later patterns block one warp through source A, source B or the destination register and then release it by a writeback or a load return. These show whether each operand check exists and whether each completion port clears the right bit. Idle stretches followed by renewed readiness show whether the round-robin position moved while nothing issued. Patterns with invalid warps, or with no pending instruction, show that eligibility depends on more than the scoreboard.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;
   localparam int unsigned WARP_THREADS = 32;
   localparam int unsigned LANE_W       = 5;

   // index width that never collapses to zero
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic [1:0] {
      SLICE_ONE  = 2'd0,
      SLICE_TWO  = 2'd1,
      SLICE_FOUR = 2'd2
   } slice_mode_e;

   function automatic slice_mode_e slice_mode(input int unsigned n);
      return (n == 4) ? SLICE_FOUR : ((n == 2) ? SLICE_TWO : SLICE_ONE);
   endfunction
endpackage

// File: rtl/warp_id_map.sv
`timescale 1ns/1ps
module warp_id_map
   import warp_sched_pkg::*;
#(
   parameter  int unsigned COORD_W   = 10,
   parameter  int unsigned NUM_SCHED = 2,
   localparam int unsigned LIN_W     = 3 * COORD_W,
   localparam int unsigned WARP_ID_W = LIN_W - LANE_W,
   localparam int unsigned SCH_W     = idx_w(NUM_SCHED)
) (
   input  logic [COORD_W-1:0]   tid_x,
   input  logic [COORD_W-1:0]   tid_y,
   input  logic [COORD_W-1:0]   tid_z,
   input  logic [COORD_W-1:0]   dim_x,
   input  logic [COORD_W-1:0]   dim_y,
   output logic [WARP_ID_W-1:0] warp_o,
   output logic [LANE_W-1:0]    lane_o,
   output logic [SCH_W-1:0]     sched_o,
   output logic [WARP_ID_W-1:0] slot_o
);
   logic [LIN_W-1:0] plane;
   logic [LIN_W-1:0] lin;

   always_comb begin
      plane = LIN_W'(dim_x) * LIN_W'(dim_y);
      lin   = LIN_W'(tid_x) + LIN_W'(tid_y) * LIN_W'(dim_x) + LIN_W'(tid_z) * plane;
   end

   assign warp_o = lin[LIN_W-1:LANE_W];
   assign lane_o = lin[LANE_W-1:0];

   generate
      if (slice_mode(NUM_SCHED) == SLICE_ONE) begin : g_single
         assign sched_o = '0;
         assign slot_o  = warp_o;
      end else begin : g_multi
         assign sched_o = warp_o[SCH_W-1:0];
         assign slot_o  = warp_o >> SCH_W;
      end
   endgenerate
endmodule

// File: rtl/warp_scoreboard.sv
`timescale 1ns/1ps
module warp_scoreboard
   import warp_sched_pkg::*;
#(
   parameter  int unsigned NUM_REGS = 8,
   localparam int unsigned REG_W    = idx_w(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [REG_W-1:0]    set_idx,
   input  logic                clr0_en,
   input  logic [REG_W-1:0]    clr0_idx,
   input  logic                clr1_en,
   input  logic [REG_W-1:0]    clr1_idx,
   input  logic [REG_W-1:0]    rd_a,
   input  logic [REG_W-1:0]    rd_b,
   input  logic [REG_W-1:0]    rd_d,
   output logic [NUM_REGS-1:0] busy_o,
   output logic                free_o
);
   logic [NUM_REGS-1:0] busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         for (int r = 0; r < NUM_REGS; r++) begin
            if (set_en && (set_idx == REG_W'(r))) begin
               busy_q[r] <= 1'b1;
            end else if ((clr0_en && (clr0_idx == REG_W'(r))) ||
                         (clr1_en && (clr1_idx == REG_W'(r)))) begin
               busy_q[r] <= 1'b0;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign free_o = !busy_q[rd_a] && !busy_q[rd_b] && !busy_q[rd_d];
endmodule

// File: rtl/warp_rr_pick.sv
`timescale 1ns/1ps
module warp_rr_pick
   import warp_sched_pkg::*;
#(
   parameter  int unsigned NUM_SLOTS = 4,
   localparam int unsigned SLOT_W    = idx_w(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] rdy_i,
   output logic                 vld_o,
   output logic [SLOT_W-1:0]    idx_o
);
   generate
      if (NUM_SLOTS == 1) begin : g_trivial
         assign vld_o = rdy_i[0];
         assign idx_o = '0;
      end else begin : g_rotate
         logic [SLOT_W-1:0] last_q;

         always_comb begin
            vld_o = 1'b0;
            idx_o = '0;
            for (int k = 1; k <= NUM_SLOTS; k++) begin
               if (!vld_o && rdy_i[(int'(last_q) + k) % NUM_SLOTS]) begin
                  vld_o = 1'b1;
                  idx_o = SLOT_W'((int'(last_q) + k) % NUM_SLOTS);
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_q <= SLOT_W'(NUM_SLOTS - 1);
            end else if (vld_o) begin
               last_q <= idx_o;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/warp_issue_sched.sv
`timescale 1ns/1ps
module warp_issue_sched
   import warp_sched_pkg::*;
#(
   parameter  int unsigned NUM_SCHED       = 2,
   parameter  int unsigned WARPS_PER_SCHED = 4,
   parameter  int unsigned NUM_REGS        = 8,
   parameter  int unsigned COORD_W         = 10,
   localparam int unsigned NUM_WARPS       = NUM_SCHED * WARPS_PER_SCHED,
   localparam int unsigned WID_W           = idx_w(NUM_WARPS),
   localparam int unsigned REG_W           = idx_w(NUM_REGS),
   localparam int unsigned SCH_W           = idx_w(NUM_SCHED),
   localparam int unsigned WARP_ID_W       = 3 * COORD_W - LANE_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [COORD_W-1:0]            tid_x,
   input  logic [COORD_W-1:0]            tid_y,
   input  logic [COORD_W-1:0]            tid_z,
   input  logic [COORD_W-1:0]            dim_x,
   input  logic [COORD_W-1:0]            dim_y,
   output logic [WARP_ID_W-1:0]          map_warp,
   output logic [LANE_W-1:0]             map_lane,
   output logic [SCH_W-1:0]              map_sched,
   output logic [WARP_ID_W-1:0]          map_slot,
   input  logic [NUM_WARPS-1:0]          warp_valid,
   input  logic [NUM_WARPS-1:0]          inst_vld,
   input  logic [NUM_WARPS*REG_W-1:0]    src_a_idx,
   input  logic [NUM_WARPS*REG_W-1:0]    src_b_idx,
   input  logic [NUM_WARPS*REG_W-1:0]    dst_idx,
   input  logic                          wb_vld,
   input  logic [WID_W-1:0]              wb_warp,
   input  logic [REG_W-1:0]              wb_reg,
   input  logic                          ld_vld,
   input  logic [WID_W-1:0]              ld_warp,
   input  logic [REG_W-1:0]              ld_reg,
   output logic [NUM_SCHED-1:0]          issue_vld,
   output logic [NUM_SCHED*WID_W-1:0]    issue_warp,
   output logic [NUM_WARPS*NUM_REGS-1:0] reg_busy
);
   localparam int unsigned SLOT_W = idx_w(WARPS_PER_SCHED);

   // elaboration-time parameter checks
   generate
      if (!(NUM_SCHED == 1 || NUM_SCHED == 2 || NUM_SCHED == 4)) begin : g_bad_sched
         $error("NUM_SCHED must be 1, 2 or 4");
      end
      if (WARPS_PER_SCHED < 1) begin : g_bad_warps
         $error("WARPS_PER_SCHED must be at least 1");
      end
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two of at least 2");
      end
      if (COORD_W < 2 || COORD_W > 16) begin : g_bad_coord
         $error("COORD_W must lie between 2 and 16");
      end
   endgenerate

   warp_id_map #(
      .COORD_W   (COORD_W),
      .NUM_SCHED (NUM_SCHED)
   ) map_i (
      .tid_x   (tid_x),
      .tid_y   (tid_y),
      .tid_z   (tid_z),
      .dim_x   (dim_x),
      .dim_y   (dim_y),
      .warp_o  (map_warp),
      .lane_o  (map_lane),
      .sched_o (map_sched),
      .slot_o  (map_slot)
   );

   logic [NUM_WARPS-1:0] sb_free;
   logic [NUM_WARPS-1:0] warp_rdy;
   logic [NUM_WARPS-1:0] warp_set;
   logic [NUM_SCHED-1:0] pick_vld;
   logic [SLOT_W-1:0]    pick_idx [NUM_SCHED];

   // one scoreboard per resident warp
   generate
      for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
         localparam int unsigned OWN_SLICE = g % NUM_SCHED;
         localparam int unsigned OWN_SLOT  = g / NUM_SCHED;

         assign warp_set[g] = pick_vld[OWN_SLICE] &&
                              (pick_idx[OWN_SLICE] == SLOT_W'(OWN_SLOT));

         warp_scoreboard #(
            .NUM_REGS (NUM_REGS)
         ) sb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (warp_set[g]),
            .set_idx  (dst_idx[g*REG_W +: REG_W]),
            .clr0_en  (wb_vld && (wb_warp == WID_W'(g))),
            .clr0_idx (wb_reg),
            .clr1_en  (ld_vld && (ld_warp == WID_W'(g))),
            .clr1_idx (ld_reg),
            .rd_a     (src_a_idx[g*REG_W +: REG_W]),
            .rd_b     (src_b_idx[g*REG_W +: REG_W]),
            .rd_d     (dst_idx[g*REG_W +: REG_W]),
            .busy_o   (reg_busy[g*NUM_REGS +: NUM_REGS]),
            .free_o   (sb_free[g])
         );

         assign warp_rdy[g] = warp_valid[g] && inst_vld[g] && sb_free[g];
      end
   endgenerate

   // one round-robin picker per scheduler slice
   generate
      for (genvar s = 0; s < NUM_SCHED; s++) begin : g_slice
         logic [WARPS_PER_SCHED-1:0] slice_rdy;

         for (genvar j = 0; j < WARPS_PER_SCHED; j++) begin : g_gather
            assign slice_rdy[j] = warp_rdy[j*NUM_SCHED + s];
         end

         warp_rr_pick #(
            .NUM_SLOTS (WARPS_PER_SCHED)
         ) rr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .rdy_i (slice_rdy),
            .vld_o (pick_vld[s]),
            .idx_o (pick_idx[s])
         );

         assign issue_vld[s] = pick_vld[s];
         assign issue_warp[s*WID_W +: WID_W] =
            WID_W'(int'(pick_idx[s]) * NUM_SCHED + s);
      end
   endgenerate
endmodule

// File: rtl/warp_issue_sched_chk.sv
`timescale 1ns/1ps
module warp_issue_sched_chk
   import warp_sched_pkg::*;
#(
   parameter  int unsigned NUM_SCHED       = 2,
   parameter  int unsigned WARPS_PER_SCHED = 4,
   parameter  int unsigned NUM_REGS        = 8,
   localparam int unsigned NUM_WARPS       = NUM_SCHED * WARPS_PER_SCHED,
   localparam int unsigned WID_W           = idx_w(NUM_WARPS),
   localparam int unsigned REG_W           = idx_w(NUM_REGS),
   localparam int unsigned BIT_W           = idx_w(NUM_WARPS * NUM_REGS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_WARPS-1:0]          warp_valid,
   input logic [NUM_WARPS-1:0]          inst_vld,
   input logic [NUM_WARPS*REG_W-1:0]    src_a_idx,
   input logic [NUM_WARPS*REG_W-1:0]    src_b_idx,
   input logic [NUM_WARPS*REG_W-1:0]    dst_idx,
   input logic                          wb_vld,
   input logic [WID_W-1:0]              wb_warp,
   input logic [REG_W-1:0]              wb_reg,
   input logic                          ld_vld,
   input logic [WID_W-1:0]              ld_warp,
   input logic [REG_W-1:0]              ld_reg,
   input logic [NUM_SCHED-1:0]          issue_vld,
   input logic [NUM_SCHED*WID_W-1:0]    issue_warp,
   input logic [NUM_WARPS*NUM_REGS-1:0] reg_busy
);
   logic [BIT_W-1:0] dst_bit [NUM_SCHED];
   logic [BIT_W-1:0] wb_bit;
   logic [BIT_W-1:0] ld_bit;
   logic             wb_overlap;
   logic             ld_overlap;

   assign wb_bit = BIT_W'(int'(wb_warp) * NUM_REGS + int'(wb_reg));
   assign ld_bit = BIT_W'(int'(ld_warp) * NUM_REGS + int'(ld_reg));

   always_comb begin
      wb_overlap = 1'b0;
      ld_overlap = 1'b0;
      for (int s = 0; s < NUM_SCHED; s++) begin
         if (issue_vld[s] && dst_bit[s] == wb_bit) wb_overlap = 1'b1;
         if (issue_vld[s] && dst_bit[s] == ld_bit) ld_overlap = 1'b1;
      end
   end

   generate
      for (genvar s = 0; s < NUM_SCHED; s++) begin : g_slice_chk
         logic [WID_W-1:0] iw;
         logic [REG_W-1:0] ra;
         logic [REG_W-1:0] rb;
         logic [REG_W-1:0] rd;

         assign iw = issue_warp[s*WID_W +: WID_W];
         assign ra = src_a_idx[int'(iw)*REG_W +: REG_W];
         assign rb = src_b_idx[int'(iw)*REG_W +: REG_W];
         assign rd = dst_idx[int'(iw)*REG_W +: REG_W];
         assign dst_bit[s] = BIT_W'(int'(iw) * NUM_REGS + int'(rd));

         // R9: only valid warps with a pending instruction are issued
         a_r9_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
            issue_vld[s] |-> (warp_valid[iw] && inst_vld[iw]));

         // R3: every operand of the issued instruction is free
         a_r3_operands_free: assert property (@(posedge clk) disable iff (!rst_n)
            issue_vld[s] |-> (!reg_busy[int'(iw)*NUM_REGS + int'(ra)] &&
                              !reg_busy[int'(iw)*NUM_REGS + int'(rb)] &&
                              !reg_busy[int'(iw)*NUM_REGS + int'(rd)]));

         // R4: the destination is marked busy after issue
         a_r4_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
            issue_vld[s] |=> reg_busy[$past(dst_bit[s])]);
      end
   endgenerate

   // R5: writeback frees its register
   a_r5_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && !wb_overlap) |=> !reg_busy[$past(wb_bit)]);

   // R6: load return frees its register
   a_r6_ld_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && !ld_overlap) |=> !reg_busy[$past(ld_bit)]);

   // R10: leaving reset with an empty busy map
   a_r10_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (reg_busy == '0));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
   .NUM_SCHED       (NUM_SCHED),
   .WARPS_PER_SCHED (WARPS_PER_SCHED),
   .NUM_REGS        (NUM_REGS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .warp_valid (warp_valid),
   .inst_vld   (inst_vld),
   .src_a_idx  (src_a_idx),
   .src_b_idx  (src_b_idx),
   .dst_idx    (dst_idx),
   .wb_vld     (wb_vld),
   .wb_warp    (wb_warp),
   .wb_reg     (wb_reg),
   .ld_vld     (ld_vld),
   .ld_warp    (ld_warp),
   .ld_reg     (ld_reg),
   .issue_vld  (issue_vld),
   .issue_warp (issue_warp),
   .reg_busy   (reg_busy)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
   localparam int S    = 2;
   localparam int W    = 4;
   localparam int NR   = 8;
   localparam int NW   = S * W;
   localparam int CW   = 10;
   localparam int WIDW = 3;
   localparam int RW   = 3;
   localparam int MW   = 3 * CW - 5;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic [CW-1:0] tx, ty, tz, dx, dy;
   logic [MW-1:0] m_warp, m_slot;
   logic [4:0]    m_lane;
   logic [0:0]    m_sched;

   logic [NW-1:0] v, iv;
   int            sa [NW];
   int            sb [NW];
   int            sd [NW];
   logic          wbv, ldv;
   int            wbw, wbr, ldw, ldr;

   logic [NW*RW-1:0]   src_a_f, src_b_f, dst_f;
   logic [S-1:0]       issue_vld;
   logic [S*WIDW-1:0]  issue_warp;
   logic [NW*NR-1:0]   reg_busy;

   always_comb begin
      for (int w = 0; w < NW; w++) begin
         src_a_f[w*RW +: RW] = RW'(sa[w]);
         src_b_f[w*RW +: RW] = RW'(sb[w]);
         dst_f[w*RW +: RW]   = RW'(sd[w]);
      end
   end

   warp_issue_sched #(
      .NUM_SCHED(S), .WARPS_PER_SCHED(W), .NUM_REGS(NR), .COORD_W(CW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tid_x(tx), .tid_y(ty), .tid_z(tz), .dim_x(dx), .dim_y(dy),
      .map_warp(m_warp), .map_lane(m_lane), .map_sched(m_sched), .map_slot(m_slot),
      .warp_valid(v), .inst_vld(iv),
      .src_a_idx(src_a_f), .src_b_idx(src_b_f), .dst_idx(dst_f),
      .wb_vld(wbv), .wb_warp(WIDW'(wbw)), .wb_reg(RW'(wbr)),
      .ld_vld(ldv), .ld_warp(WIDW'(ldw)), .ld_reg(RW'(ldr)),
      .issue_vld(issue_vld), .issue_warp(issue_warp), .reg_busy(reg_busy)
   );

   int checks = 0;
   int errors = 0;
   bit mb [NW][NR];
   int mptr [S];

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit mready(input int w);
      return v[w] && iv[w] && !mb[w][sa[w]] && !mb[w][sb[w]] && !mb[w][sd[w]];
   endfunction

   // check one cycle against the reference model, then advance one clock
   task automatic step(input string req);
      bit          ev [S];
      int          ew [S];
      logic [63:0] eb;
      #1;
      for (int s = 0; s < S; s++) begin
         ev[s] = 1'b0;
         ew[s] = 0;
         for (int k = 1; k <= W; k++) begin
            int slot;
            slot = (mptr[s] + k) % W;
            if (!ev[s] && mready(slot * S + s)) begin
               ev[s] = 1'b1;
               ew[s] = slot * S + s;
            end
         end
         chk(req, $sformatf("issue_vld[%0d]", s), 64'(issue_vld[s]), 64'(ev[s]));
         if (ev[s]) chk(req, $sformatf("issue_warp[%0d]", s),
                        64'(issue_warp[s*WIDW +: WIDW]), 64'(ew[s]));
      end
      eb = '0;
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) eb[w*NR + r] = mb[w][r];
      chk(req, "reg_busy", 64'(reg_busy), eb);
      if (wbv) mb[wbw][wbr] = 1'b0;
      if (ldv) mb[ldw][ldr] = 1'b0;
      for (int s = 0; s < S; s++) begin
         if (ev[s]) begin
            mb[ew[s]][sd[ew[s]]] = 1'b1;
            mptr[s] = ew[s] / S;
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      v = '0; iv = '0; wbv = 1'b0; ldv = 1'b0;
      wbw = 0; wbr = 0; ldw = 0; ldr = 0;
      for (int w = 0; w < NW; w++) begin sa[w] = 0; sb[w] = 0; sd[w] = 0; end
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) mb[w][r] = 1'b0;
      for (int s = 0; s < S; s++) mptr[s] = W - 1;
   endtask

   task automatic map_case(input int x, input int y, input int z, input int ddx, input int ddy);
      int lin, wp;
      tx = CW'(x); ty = CW'(y); tz = CW'(z); dx = CW'(ddx); dy = CW'(ddy);
      #1;
      lin = x + y * ddx + z * ddx * ddy;
      wp  = lin / 32;
      chk("R1", "map_warp", 64'(m_warp), 64'(wp));
      chk("R1", "map_lane", 64'(m_lane), 64'(lin % 32));
      chk("R2", "map_sched", 64'(m_sched), 64'(wp % S));
      chk("R2", "map_slot", 64'(m_slot), 64'(wp / S));
   endtask

   task automatic t_reset();
      do_reset();
      v = '1; iv = '1;
      for (int w = 0; w < NW; w++) sd[w] = 2;
      step("R10");
      step("R10");
      do_reset();
      #1;
      chk("R10", "reg_busy after reset", 64'(reg_busy), 64'(0));
      chk("R10", "issue_vld idle", 64'(issue_vld), 64'(0));
   endtask

   task automatic t_map();
      map_case(3, 2, 1, 8, 4);
      map_case(15, 15, 3, 16, 16);
      map_case(200, 0, 0, 256, 1);
   endtask

   task automatic t_rr();
      do_reset();
      v = '1; iv = '1;
      for (int c = 0; c < 6; c++) begin
         for (int w = 0; w < NW; w++) sd[w] = c + 1;
         step("R7 R11 R2 R4");
      end
   endtask

   task automatic t_stall();
      do_reset();
      v = 8'b0000_0001; iv = 8'b0000_0001; sd[0] = 5;
      step("R3");
      v = 8'b0000_0101; iv = 8'b0000_0101; sa[0] = 5; sd[2] = 1;
      step("R3");
      wbv = 1'b1; wbw = 0; wbr = 5;
      step("R3 stall");
      wbv = 1'b0;
      step("R5");
      ldv = 1'b1; ldw = 0; ldr = 5; wbv = 1'b1; wbw = 2; wbr = 1;
      step("R6 R3 dst");
      ldv = 1'b0; wbv = 1'b0;
      step("R6");
   endtask

   task automatic t_srcb();
      do_reset();
      v = 8'b0000_0011; iv = 8'b0000_0011; sd[0] = 3; sd[1] = 6;
      step("R3");
      sb[0] = 3; sd[0] = 4; sb[1] = 6; sd[1] = 7;
      step("R3 srcb");
      ldv = 1'b1; ldw = 0; ldr = 3;
      step("R3 srcb");
      ldv = 1'b0;
      step("R11 R6");
   endtask

   task automatic t_invalid();
      do_reset();
      v = 8'b1010_1010; iv = 8'b1111_0111;
      for (int c = 0; c < 4; c++) begin
         for (int w = 0; w < NW; w++) sd[w] = c + 1;
         step("R9");
      end
   endtask

   task automatic t_idle();
      do_reset();
      v = 8'b0000_0100; iv = 8'b0000_0100; sa[2] = 1; sd[2] = 3;
      step("R8");
      v = '0; iv = '0;
      step("R8");
      step("R8");
      step("R8");
      v = 8'b0101_0101; iv = 8'b0101_0101;
      for (int w = 0; w < NW; w++) sd[w] = 4;
      step("R8 resume");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tx = '0; ty = '0; tz = '0; dx = '0; dy = '0;
      t_reset();
      t_map();
      t_rr();
      t_stall();
      t_srcb();
      t_invalid();
      t_idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule